// File: doc/BRIEF.md
# Processor-Interface Exception Status Collector

This block gathers single-cycle fault pulses from two processor ports and from a memory ECC checker that covers an upper and a lower data half. Each pulse lands in a sticky status bit that stays set until software reads the status register. An enable mask, which software can read and write, selects which sticky bits drive a single level-sensitive interrupt line. Three group flags report enabled faults by kind: processor-side, uncorrectable ECC and correctable ECC.

Software reaches the two registers over a simple register bus: a select strobe, a write strobe, a byte address and 32-bit data. Read data is registered and appears one cycle after the access. Reading the status register returns the captured faults and empties the register in the same access. A fault that arrives in the cycle of that read is kept for the next read. Register bits are numbered from the most significant end: register bit n is word bit 31 − n.

Top module: `pi_exc_status`

## Requirements
- R1: After reset the status register reads 0x00000000, the mask register reads 0xFEF00000 (every implemented source enabled), and the interrupt and all group flags are low.
- R2: A one-cycle pulse on processor source n (pi_evt[n], n = 0..6) sets word bit 31 − n. A pulse on ecc_evt[k] (k = 0 uncorrectable upper, 1 correctable upper, 2 uncorrectable lower, 3 correctable lower) sets word bit 23 − k. A set bit stays set until a status read.
- R3: A read at address 0x00 returns the status value held before the access on reg_rdata one cycle later, and leaves the status at zero when no new fault arrives in that cycle.
- R4: A fault that arrives in the same cycle as a status read is absent from that read's data and present in the status afterwards.
- R5: A write at address 0x10 loads the mask. Word bits 24 and 0–19 are reserved; they read 0 in both registers and are never set.
- R6: irq is high exactly when some status bit and the matching mask bit are both set. A masked fault is still recorded in the status.
- R7: flt_proc is high when any enabled status bit among word bits 31–25 is set. flt_ue is high for enabled bits 23 or 21. flt_ce is high for enabled bits 22 or 20.
- R8: A write to the status address has no effect. A read of any address other than 0x00 or 0x10 returns 0 and changes neither register.
- R9: Reading the mask register does not clear the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pi_evt | input | 7 | Processor-side fault pulses, index = register bit number |
| ecc_evt | input | 4 | ECC fault pulses: UE upper, CE upper, UE lower, CE lower |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| irq | output | 1 | Level interrupt, OR of enabled status bits |
| flt_proc | output | 1 | Enabled processor-side fault present |
| flt_ue | output | 1 | Enabled uncorrectable ECC fault present |
| flt_ce | output | 1 | Enabled correctable ECC fault present |

## Verification
A corrupted sticky bit shows on irq and the group flags in the cycle after the fault, if the mask enables it. It shows on reg_rdata one cycle after the next status read. A lost fault during a clearing read is not visible in that read. It appears only in the value returned by the following read, so the bench always does a second read after a collision. A mask bit that holds a wrong value shows on irq as soon as a fault on that source arrives. The reference model is compared on every clock, so such a divergence is reported within one cycle of becoming observable.

// File: rtl/pi_exc_pkg.sv
package pi_exc_pkg;

    localparam int WORD_W   = 32;
    localparam int N_PI     = 7;
    localparam int N_ECC    = 4;
    localparam int ECC_BASE = 8;
    localparam int ADDR_W   = 8;

    localparam logic [ADDR_W-1:0] STATUS_ADDR = 8'h00;
    localparam logic [ADDR_W-1:0] MASK_ADDR   = 8'h10;

    // register bit n lives at word bit WORD_W-1-n
    function automatic int word_pos(input int n);
        return WORD_W - 1 - n;
    endfunction

    function automatic logic [WORD_W-1:0] proc_group();
        logic [WORD_W-1:0] v;
        v = '0;
        for (int i = 0; i < N_PI; i++) v[word_pos(i)] = 1'b1;
        return v;
    endfunction

    // ecc index parity: even = uncorrectable, odd = correctable
    function automatic logic [WORD_W-1:0] ecc_group(input logic odd);
        logic [WORD_W-1:0] v;
        v = '0;
        for (int k = 0; k < N_ECC; k++)
            if ((k % 2) == int'(odd)) v[word_pos(ECC_BASE + k)] = 1'b1;
        return v;
    endfunction

    localparam logic [WORD_W-1:0] GRP_PROC = proc_group();
    localparam logic [WORD_W-1:0] GRP_UE   = ecc_group(1'b0);
    localparam logic [WORD_W-1:0] GRP_CE   = ecc_group(1'b1);
    localparam logic [WORD_W-1:0] IMPL     = GRP_PROC | GRP_UE | GRP_CE;

    typedef struct packed {
        logic [WORD_W-1:0] status;
    } stat_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] mask;
    } mask_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
    } bus_state_t;

endpackage

// File: rtl/pi_exc_evt_map.sv
module pi_exc_evt_map
    import pi_exc_pkg::*;
(
    input  logic [N_PI-1:0]   pi_evt,
    input  logic [N_ECC-1:0]  ecc_evt,
    output logic [WORD_W-1:0] evt_word
);

    logic [WORD_W-1:0] pi_part;
    logic [WORD_W-1:0] ecc_part;

    genvar gi;
    generate
        for (gi = 0; gi < WORD_W; gi++) begin : g_bit
            localparam int RBIT = WORD_W - 1 - gi;
            if (RBIT < N_PI) begin : g_pi
                assign pi_part[gi]  = pi_evt[RBIT];
                assign ecc_part[gi] = 1'b0;
            end else if (RBIT >= ECC_BASE && RBIT < ECC_BASE + N_ECC) begin : g_ecc
                assign pi_part[gi]  = 1'b0;
                assign ecc_part[gi] = ecc_evt[RBIT - ECC_BASE];
            end else begin : g_rsv
                assign pi_part[gi]  = 1'b0;
                assign ecc_part[gi] = 1'b0;
            end
        end
    endgenerate

    assign evt_word = pi_part | ecc_part;

endmodule

// File: rtl/pi_exc_status_reg.sv
module pi_exc_status_reg
    import pi_exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] set_vec,
    input  logic              clr,
    output logic [WORD_W-1:0] status
);

    stat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.status = '0;
        // new faults win over the clear so none is dropped
        st_d.status = (st_d.status | set_vec) & IMPL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.status;

endmodule

// File: rtl/pi_exc_mask_reg.sv
module pi_exc_mask_reg
    import pi_exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] mask
);

    mask_state_t mk_d, mk_q;

    always_comb begin
        mk_d = mk_q;
        if (wr_en) mk_d.mask = wdata & IMPL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mk_q.mask <= IMPL;
        else        mk_q      <= mk_d;
    end

    assign mask = mk_q.mask;

endmodule

// File: rtl/pi_exc_bus.sv
module pi_exc_bus
    import pi_exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] status,
    input  logic [WORD_W-1:0] mask,
    output logic              mask_wr,
    output logic              status_rd,
    output logic [WORD_W-1:0] rdata
);

    bus_state_t bs_d, bs_q;
    logic       rd;
    logic       mask_rd;

    assign rd        = reg_sel && !reg_wr;
    assign status_rd = rd && (reg_addr == STATUS_ADDR);
    assign mask_rd   = rd && (reg_addr == MASK_ADDR);
    assign mask_wr   = reg_sel && reg_wr && (reg_addr == MASK_ADDR);

    always_comb begin
        bs_d = bs_q;
        if (rd) begin
            if (status_rd)    bs_d.rdata = status;
            else if (mask_rd) bs_d.rdata = mask;
            else              bs_d.rdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bs_q <= '0;
        else        bs_q <= bs_d;
    end

    assign rdata = bs_q.rdata;

endmodule

// File: rtl/pi_exc_summary.sv
module pi_exc_summary
    import pi_exc_pkg::*;
(
    input  logic [WORD_W-1:0] status,
    input  logic [WORD_W-1:0] mask,
    output logic              irq,
    output logic              flt_proc,
    output logic              flt_ue,
    output logic              flt_ce
);

    logic [WORD_W-1:0] live;

    always_comb begin
        live     = status & mask;
        irq      = |live;
        flt_proc = |(live & GRP_PROC);
        flt_ue   = |(live & GRP_UE);
        flt_ce   = |(live & GRP_CE);
    end

endmodule

// File: rtl/pi_exc_status.sv
module pi_exc_status
    import pi_exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PI-1:0]   pi_evt,
    input  logic [N_ECC-1:0]  ecc_evt,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq,
    output logic              flt_proc,
    output logic              flt_ue,
    output logic              flt_ce
);

    logic [WORD_W-1:0] evt_word;
    logic [WORD_W-1:0] status_vec;
    logic [WORD_W-1:0] mask_vec;
    logic              mask_wr;
    logic              status_rd;

    pi_exc_evt_map u_map (
        .pi_evt   (pi_evt),
        .ecc_evt  (ecc_evt),
        .evt_word (evt_word)
    );

    pi_exc_status_reg u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (evt_word),
        .clr     (status_rd),
        .status  (status_vec)
    );

    pi_exc_mask_reg u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (mask_wr),
        .wdata (reg_wdata),
        .mask  (mask_vec)
    );

    pi_exc_bus u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .status    (status_vec),
        .mask      (mask_vec),
        .mask_wr   (mask_wr),
        .status_rd (status_rd),
        .rdata     (reg_rdata)
    );

    pi_exc_summary u_sum (
        .status   (status_vec),
        .mask     (mask_vec),
        .irq      (irq),
        .flt_proc (flt_proc),
        .flt_ue   (flt_ue),
        .flt_ce   (flt_ce)
    );

endmodule

// File: rtl/pi_exc_status_chk.sv
module pi_exc_status_chk
    import pi_exc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_status,
    input logic              mask_wr,
    input logic [WORD_W-1:0] evt_word,
    input logic [WORD_W-1:0] status_q,
    input logic [WORD_W-1:0] mask_q,
    input logic [WORD_W-1:0] rdata,
    input logic              irq
);

    a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_status |=> ((status_q & $past(status_q)) == $past(status_q)));

    a_r3_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && evt_word == '0) |=> (status_q == '0));

    a_r3_read_data: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status |=> (rdata == $past(status_q)));

    a_r4_keep_collision: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status |=> ((status_q & $past(evt_word)) == $past(evt_word)));

    a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask_q & ~IMPL) == '0) && ((status_q & ~IMPL) == '0));

    a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past((evt_word != '0) || mask_wr));

endmodule

bind pi_exc_status pi_exc_status_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_status (status_rd),
    .mask_wr   (mask_wr),
    .evt_word  (evt_word),
    .status_q  (status_vec),
    .mask_q    (mask_vec),
    .rdata     (reg_rdata),
    .irq       (irq)
);

// File: tb/pi_exc_status_tb.sv
`timescale 1ns/1ps
module pi_exc_status_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  pi_evt = '0;
    logic [3:0]  ecc_evt = '0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, flt_proc, flt_ue, flt_ce;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pi_exc_status u_dut (
        .clk(clk), .rst_n(rst_n), .pi_evt(pi_evt), .ecc_evt(ecc_evt),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .flt_proc(flt_proc), .flt_ue(flt_ue), .flt_ce(flt_ce)
    );

    // behavioural reference model
    logic [31:0] m_status, m_mask, m_rdata;
    localparam logic [31:0] LEGAL = 32'hFEF0_0000;

    always @(posedge clk) begin
        logic [31:0] ev;
        ev = '0;
        for (int n = 0; n < 7; n++) if (pi_evt[n]) ev[31-n] = 1'b1;
        for (int k = 0; k < 4; k++) if (ecc_evt[k]) ev[23-k] = 1'b1;
        if (!rst_n) begin
            m_status <= '0;
            m_mask   <= LEGAL;
            m_rdata  <= '0;
        end else begin
            if (reg_sel && !reg_wr) begin
                if (reg_addr == 8'h00)      m_rdata <= m_status;
                else if (reg_addr == 8'h10) m_rdata <= m_mask;
                else                        m_rdata <= '0;
            end
            if (reg_sel && !reg_wr && reg_addr == 8'h00) m_status <= ev;
            else                                         m_status <= m_status | ev;
            if (reg_sel && reg_wr && reg_addr == 8'h10) m_mask <= reg_wdata & LEGAL;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            logic [31:0] live;
            live = m_status & m_mask;
            chk("R6 irq", {31'd0, irq}, {31'd0, |live});
            chk("R7 flt_proc", {31'd0, flt_proc}, {31'd0, |(live & 32'hFE00_0000)});
            chk("R7 flt_ue", {31'd0, flt_ue}, {31'd0, |(live & 32'h00A0_0000)});
            chk("R7 flt_ce", {31'd0, flt_ce}, {31'd0, |(live & 32'h0050_0000)});
            chk("R3 rdata", reg_rdata, m_rdata);
        end
    end

    // one clock of stimulus, then back to idle
    task automatic cyc(input logic s, input logic w, input logic [7:0] a,
                       input logic [31:0] d, input logic [6:0] p, input logic [3:0] e);
        reg_sel = s; reg_wr = w; reg_addr = a; reg_wdata = d;
        pi_evt = p; ecc_evt = e;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        pi_evt = '0; ecc_evt = '0;
    endtask

    task automatic rd(input logic [7:0] a);
        cyc(1'b1, 1'b0, a, '0, '0, '0);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rd(8'h10); chk("R1 mask", reg_rdata, 32'hFEF0_0000);
        rd(8'h00); chk("R1 status", reg_rdata, 32'h0);

        // R2 capture and hold
        cyc(1'b0, 1'b0, '0, '0, 7'b000_0001, 4'b0000);
        repeat (3) @(negedge clk);
        chk("R2 held irq", {31'd0, irq}, 32'd1);
        cyc(1'b0, 1'b0, '0, '0, '0, 4'b1000);
        rd(8'h00); chk("R2 status", reg_rdata, 32'h8010_0000);
        // R3 cleared
        rd(8'h00); chk("R3 cleared", reg_rdata, 32'h0);

        // R7 groups
        cyc(1'b0, 1'b0, '0, '0, '0, 4'b0001);
        chk("R7 ue", {29'd0, flt_proc, flt_ue, flt_ce}, 32'b010);
        rd(8'h00); chk("R7 ue bit", reg_rdata, 32'h0080_0000);

        // R4 collision with a clearing read
        cyc(1'b0, 1'b0, '0, '0, 7'b000_0001, 4'b0000);
        cyc(1'b1, 1'b0, 8'h00, '0, 7'b010_0000, 4'b0000);
        chk("R4 old data", reg_rdata, 32'h8000_0000);
        chk("R4 irq kept", {31'd0, irq}, 32'd1);
        rd(8'h00); chk("R4 kept", reg_rdata, 32'h0400_0000);

        // R5 mask write, reserved bits
        cyc(1'b1, 1'b1, 8'h10, 32'hFFFF_FFFF, '0, '0);
        rd(8'h10); chk("R5 all", reg_rdata, 32'hFEF0_0000);
        cyc(1'b1, 1'b1, 8'h10, 32'h0, '0, '0);
        rd(8'h10); chk("R5 none", reg_rdata, 32'h0);
        // R6 masked fault still recorded
        cyc(1'b0, 1'b0, '0, '0, 7'b000_0010, 4'b0000);
        chk("R6 masked irq", {31'd0, irq}, 32'd0);
        rd(8'h00); chk("R6 masked recorded", reg_rdata, 32'h4000_0000);
        cyc(1'b1, 1'b1, 8'h10, 32'h0040_0000, '0, '0);
        cyc(1'b0, 1'b0, '0, '0, '0, 4'b0100);
        chk("R6 other src", {31'd0, irq}, 32'd0);
        cyc(1'b0, 1'b0, '0, '0, '0, 4'b0010);
        chk("R6 enabled src", {31'd0, irq}, 32'd1);
        chk("R7 ce", {29'd0, flt_proc, flt_ue, flt_ce}, 32'b001);

        // R9 mask read keeps status
        rd(8'h10); chk("R9 mask", reg_rdata, 32'h0040_0000);
        chk("R9 irq", {31'd0, irq}, 32'd1);
        rd(8'h00); chk("R9 status", reg_rdata, 32'h0060_0000);

        // R8 status write and unmapped read
        cyc(1'b1, 1'b1, 8'h00, 32'hFFFF_FFFF, '0, '0);
        rd(8'h00); chk("R8 write ignored", reg_rdata, 32'h0);
        cyc(1'b0, 1'b0, '0, '0, 7'b100_0000, 4'b0000);
        rd(8'h08); chk("R8 unmapped", reg_rdata, 32'h0);
        rd(8'h10); chk("R8 mask kept", reg_rdata, 32'h0040_0000);
        rd(8'h00); chk("R8 status kept", reg_rdata, 32'h0200_0000);

        repeat (2) @(negedge clk);
        summary();
    end

endmodule